// File: doc/BRIEF.md
# Concurrent-Write Shared Register File

A small bank of shared cells that several processor ports reach in the same clock cycle. Each port has its own read enable, read address, write enable, write address and write data. A two-bit mode input picks the access discipline. In exclusive mode every cell takes at most one access per cycle. In read-shared mode any number of reads may land on a cell, but only one write. In fully concurrent mode several writes may land on one cell, and a three-bit policy input says how that collision is settled.

Reads are combinational from the current contents. Writes to a cell that break no rule are committed on the rising clock edge. There is no stream interface and no back-pressure: every access is accepted in the cycle it is presented. Two registered flags, collision and violation, report what happened in the previous cycle.

Top module: `pram_crcw_regfile`

## Requirements
- R1: An active-low asynchronous reset clears every cell, both flags and the rotation pointer to zero.
- R2: Each port's read data is the cell selected by its read address, shown combinationally. A read of a cell in the same cycle as a write to it returns the value held before that write.
- R3: With mode 0 (exclusive), a cell targeted by more than one access in a cycle counts as a violation. Accesses are enabled reads and writes taken together, so two reads also count. The cell keeps its old value, and a write that hits some other cell without breaking any rule still commits.
- R4: With mode 1 (read-shared), any number of reads of one cell is legal. Two or more writes to one cell are a violation and leave the cell unchanged.
- R5: With mode 2 or 3 (concurrent) and policy 0 (common), colliding writers that all present the same value store that value, with a collision but no violation. If the values differ, the write is a violation and the cell is unchanged.
- R6: Policy 1 (arbitrary) keeps a rotation pointer that starts at 0. The winner is the first writer at or above the pointer, wrapping past the highest port index. The pointer advances by one, modulo the port count, after every cycle in which at least one cell had a collision under this policy. A lone writer does not move the pointer.
- R7: Policy 2 (rank) stores the value of the lowest-indexed writer. Codes 6 and 7 behave as rank.
- R8: Policy 3 stores the sum of all colliding values, wrapped modulo 2^W.
- R9: Policy 4 stores the bitwise AND of all colliding values.
- R10: Policy 5 stores the largest of the colliding values, compared as unsigned numbers.
- R11: Collision is high in the cycle after any cell saw two or more writes, or (in mode 0) two or more accesses. Violation is high in the cycle after any rule was broken. Each flag is high for exactly one cycle per offending cycle, and violation never appears without collision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Access discipline: 0 exclusive, 1 read-shared, 2/3 concurrent |
| policy_i | input | 3 | Concurrent write policy code |
| rd_en_i | input | N | Per-port read enable, used for the exclusive rule |
| rd_addr_i | input | N*AW | Per-port read address, port p in bits p*AW upward |
| rd_data_o | output | N*W | Per-port read data, port p in bits p*W upward |
| wr_en_i | input | N | Per-port write enable |
| wr_addr_i | input | N*AW | Per-port write address |
| wr_data_i | input | N*W | Per-port write data |
| conflict_o | output | 1 | Collision seen in the previous cycle |
| illegal_o | output | 1 | Rule violation seen in the previous cycle |

## Verification
Conflict detection and write commitment meet in one cycle when one cell breaks a rule while another port writes a different cell. The bench provokes this by pairing a two-writer collision with an unrelated single write. It then reads both cells back through the read ports, expecting the collided cell to be unchanged and the other cell to be updated, while the flags for that cycle come out of the scoreboard queue. The bench also reads a cell in the same cycle as it is written, expecting the value held before the write.

// File: rtl/pram_pkg.sv
package pram_pkg;

  typedef enum logic [1:0] {
    ACC_EXCL     = 2'd0,
    ACC_CREAD    = 2'd1,
    ACC_CONC     = 2'd2,
    ACC_CONC_ALT = 2'd3
  } acc_mode_e;

  typedef enum logic [2:0] {
    WP_COMMON = 3'd0,
    WP_ARB    = 3'd1,
    WP_RANK   = 3'd2,
    WP_SUM    = 3'd3,
    WP_AND    = 3'd4,
    WP_MAX    = 3'd5,
    WP_RSV6   = 3'd6,
    WP_RSV7   = 3'd7
  } wr_pol_e;

  function automatic logic is_conc(acc_mode_e m);
    return (m == ACC_CONC) || (m == ACC_CONC_ALT);
  endfunction

endpackage

// File: rtl/pram_hit_decode.sv
module pram_hit_decode #(
  parameter int N     = 4,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic [N-1:0]       rd_en_i,
  input  logic [N*AW-1:0]    rd_addr_i,
  input  logic [N-1:0]       wr_en_i,
  input  logic [N*AW-1:0]    wr_addr_i,
  output logic [DEPTH*N-1:0] rhit_o,
  output logic [DEPTH*N-1:0] whit_o
);

  // One hit bit per (cell, port): cell c, port p lives at c*N+p.
  for (genvar c = 0; c < DEPTH; c++) begin : g_cell
    localparam logic [AW-1:0] CELL_ADDR = AW'(c);
    for (genvar p = 0; p < N; p++) begin : g_port
      assign whit_o[c*N+p] = wr_en_i[p] && (wr_addr_i[p*AW +: AW] == CELL_ADDR);
      assign rhit_o[c*N+p] = rd_en_i[p] && (rd_addr_i[p*AW +: AW] == CELL_ADDR);
    end
  end

endmodule

// File: rtl/pram_cell_resolve.sv
module pram_cell_resolve
  import pram_pkg::*;
#(
  parameter int N  = 4,
  parameter int W  = 8,
  parameter int PW = 2
) (
  input  acc_mode_e      mode_i,
  input  wr_pol_e        pol_i,
  input  logic [N-1:0]   wmask_i,
  input  logic [N-1:0]   rmask_i,
  input  logic [N*W-1:0] wdata_i,
  input  logic [PW-1:0]  ptr_i,
  output logic           commit_o,
  output logic [W-1:0]   value_o,
  output logic           collide_o,
  output logic           viol_o,
  output logic           arb_step_o
);

  int           n_wr, n_rd;
  logic [W-1:0] rank_val, arb_val, sum_val, and_val, max_val;
  logic [N-1:0] arb_sel;
  logic         mismatch, arb_found;

  always_comb begin
    n_wr = $countones(wmask_i);
    n_rd = $countones(rmask_i);

    // lowest-indexed writer
    rank_val = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (wmask_i[i]) rank_val = wdata_i[i*W +: W];
    end

    // rotating choice: first writer at or above the pointer, wrapping
    arb_sel   = '0;
    arb_found = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr_i) + k) % N;
      if (!arb_found && wmask_i[idx]) begin
        arb_found    = 1'b1;
        arb_sel[idx] = 1'b1;
      end
    end
    arb_val = '0;
    for (int i = 0; i < N; i++) begin
      if (arb_sel[i]) arb_val = arb_val | wdata_i[i*W +: W];
    end

    // reductions
    sum_val  = '0;
    and_val  = '1;
    max_val  = '0;
    mismatch = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (wmask_i[i]) begin
        sum_val = sum_val + wdata_i[i*W +: W];
        and_val = and_val & wdata_i[i*W +: W];
        if (wdata_i[i*W +: W] > max_val) max_val = wdata_i[i*W +: W];
        if (wdata_i[i*W +: W] != rank_val) mismatch = 1'b1;
      end
    end

    unique case (mode_i)
      ACC_EXCL:  viol_o = (n_wr + n_rd) > 1;
      ACC_CREAD: viol_o = n_wr > 1;
      default:   viol_o = (pol_i == WP_COMMON) && mismatch;
    endcase

    collide_o  = (n_wr > 1) || ((mode_i == ACC_EXCL) && ((n_wr + n_rd) > 1));
    commit_o   = (n_wr > 0) && !viol_o;
    arb_step_o = is_conc(mode_i) && (pol_i == WP_ARB) && (n_wr > 1);

    unique case (pol_i)
      WP_ARB:  value_o = arb_val;
      WP_SUM:  value_o = sum_val;
      WP_AND:  value_o = and_val;
      WP_MAX:  value_o = max_val;
      default: value_o = rank_val;
    endcase
  end

  always_comb begin
    AST_ARB_ONEHOT: assert ($onehot0(arb_sel)) else $error("arbitrary pick not one-hot"); // R6
    for (int i = 0; i < N; i++) begin
      if (commit_o && is_conc(mode_i) && wmask_i[i]) begin
        if (pol_i == WP_MAX) begin
          AST_MAX_BOUND: assert (value_o >= wdata_i[i*W +: W]) else $error("max below a writer"); // R10
        end
        if (pol_i == WP_COMMON) begin
          AST_COMMON_UNIFORM: assert (value_o == wdata_i[i*W +: W]) else $error("common value differs"); // R5
        end
      end
    end
  end

endmodule

// File: rtl/pram_crcw_regfile.sv
module pram_crcw_regfile
  import pram_pkg::*;
#(
  parameter  int N     = 4,
  parameter  int W     = 8,
  parameter  int DEPTH = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     mode_i,
  input  logic [2:0]     policy_i,
  input  logic [N-1:0]   rd_en_i,
  input  logic [N*AW-1:0] rd_addr_i,
  output logic [N*W-1:0] rd_data_o,
  input  logic [N-1:0]   wr_en_i,
  input  logic [N*AW-1:0] wr_addr_i,
  input  logic [N*W-1:0] wr_data_i,
  output logic           conflict_o,
  output logic           illegal_o
);

  localparam int PW = (N > 1) ? $clog2(N) : 1;

  acc_mode_e mode;
  wr_pol_e   pol;
  assign mode = acc_mode_e'(mode_i);
  assign pol  = wr_pol_e'(policy_i);

  logic [W-1:0]       mem [DEPTH];
  logic [PW-1:0]      ptr;
  logic [DEPTH*N-1:0] rhit, whit;
  logic [DEPTH-1:0]   commit, collide, viol, arb_step;
  logic [W-1:0]       nxt [DEPTH];

  pram_hit_decode #(.N(N), .DEPTH(DEPTH), .AW(AW)) u_decode (
    .rd_en_i  (rd_en_i),
    .rd_addr_i(rd_addr_i),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .rhit_o   (rhit),
    .whit_o   (whit)
  );

  for (genvar c = 0; c < DEPTH; c++) begin : g_cell
    pram_cell_resolve #(.N(N), .W(W), .PW(PW)) u_resolve (
      .mode_i    (mode),
      .pol_i     (pol),
      .wmask_i   (whit[c*N +: N]),
      .rmask_i   (rhit[c*N +: N]),
      .wdata_i   (wr_data_i),
      .ptr_i     (ptr),
      .commit_o  (commit[c]),
      .value_o   (nxt[c]),
      .collide_o (collide[c]),
      .viol_o    (viol[c]),
      .arb_step_o(arb_step[c])
    );

    AST_VIOL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      viol[c] |=> $stable(mem[c])) else $error("violated cell changed"); // R3
  end

  // combinational reads of current contents
  for (genvar p = 0; p < N; p++) begin : g_read
    logic [AW-1:0] ra;
    assign ra = rd_addr_i[p*AW +: AW];
    assign rd_data_o[p*W +: W] = (int'(ra) < DEPTH) ? mem[ra] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < DEPTH; c++) mem[c] <= '0;
      ptr        <= '0;
      conflict_o <= 1'b0;
      illegal_o  <= 1'b0;
    end else begin
      for (int c = 0; c < DEPTH; c++) begin
        if (commit[c]) mem[c] <= nxt[c];
      end
      if (|arb_step) ptr <= (ptr == PW'(N - 1)) ? '0 : ptr + 1'b1;
      conflict_o <= |collide;
      illegal_o  <= |viol;
    end
  end

  AST_ILLEGAL_WITH_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> conflict_o) else $error("violation without collision"); // R11

  AST_QUIET_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !(|collide) |=> !conflict_o && !illegal_o) else $error("flag without cause"); // R11

  if (N > 1) begin : g_ptr_chk
    AST_ARB_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
      (|arb_step) |=> ptr != $past(ptr)) else $error("pointer stuck"); // R6
  end

endmodule

// File: tb/pram_crcw_regfile_tb.sv
`timescale 1ns/100ps
module pram_crcw_regfile_tb;
  localparam int N = 4, W = 8, DEPTH = 16, AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]      mode;
  logic [2:0]      policy;
  logic [N-1:0]    rd_en, wr_en;
  logic [N*AW-1:0] rd_addr, wr_addr;
  logic [N*W-1:0]  wr_data, rd_data;
  logic            conflict, illegal;

  pram_crcw_regfile #(.N(N), .W(W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .policy_i(policy),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .conflict_o(conflict), .illegal_o(illegal)
  );

  int n_vec = 0, n_bad = 0;
  logic [W-1:0] model [DEPTH];
  int mptr = 0;

  typedef struct { logic c; logic i; string req; } exp_t;
  exp_t sb [$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  task automatic clr();
    rd_en = '0; wr_en = '0; rd_addr = '0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic wr(input int p, input int a, input logic [W-1:0] d);
    wr_en[p] = 1'b1; wr_addr[p*AW +: AW] = AW'(a); wr_data[p*W +: W] = d;
  endtask

  task automatic rd(input int p, input int a);
    rd_en[p] = 1'b1; rd_addr[p*AW +: AW] = AW'(a);
  endtask

  // quiet read of one cell through port 0, no clock edge
  task automatic peek(input string req, input int a, input logic [W-1:0] v);
    clr(); mode = 2'd1; rd(0, a); #1;
    chk(req, rd_data[W-1:0], v);
    clr();
  endtask

  // one access cycle: checks reads, updates the model, queues expected flags
  task automatic go(input string req, input logic [1:0] md, input logic [2:0] pol);
    logic [W-1:0] nm [DEPTH];
    logic ecol, evio, arbhit;
    exp_t e;
    mode = md; policy = pol; #1;
    for (int p = 0; p < N; p++) chk(req, rd_data[p*W +: W], model[rd_addr[p*AW +: AW]]);
    ecol = 0; evio = 0; arbhit = 0;
    for (int c = 0; c < DEPTH; c++) begin
      int nw, nr;
      logic [W-1:0] first, val, s, an, mx;
      logic mism, v, fnd;
      nw = 0; nr = 0; mism = 0; first = '0; s = '0; an = '1; mx = '0; val = '0; fnd = 0;
      nm[c] = model[c];
      for (int p = 0; p < N; p++) begin
        if (rd_en[p] && rd_addr[p*AW +: AW] == AW'(c)) nr++;
        if (wr_en[p] && wr_addr[p*AW +: AW] == AW'(c)) begin
          if (nw == 0) first = wr_data[p*W +: W];
          else if (wr_data[p*W +: W] != first) mism = 1;
          nw++;
          s  = s + wr_data[p*W +: W];
          an = an & wr_data[p*W +: W];
          if (wr_data[p*W +: W] > mx) mx = wr_data[p*W +: W];
        end
      end
      if (md == 0)      v = (nw + nr) > 1;
      else if (md == 1) v = nw > 1;
      else              v = (pol == 0) && mism;
      if (nw > 1 || (md == 0 && nw + nr > 1)) ecol = 1;
      if (v) evio = 1;
      if (md >= 2 && pol == 1 && nw > 1) arbhit = 1;
      case (pol)
        3'd1: begin
          for (int k = 0; k < N; k++) begin
            int q;
            q = (mptr + k) % N;
            if (!fnd && wr_en[q] && wr_addr[q*AW +: AW] == AW'(c)) begin
              fnd = 1; val = wr_data[q*W +: W];
            end
          end
        end
        3'd3: val = s;
        3'd4: val = an;
        3'd5: val = mx;
        default: val = first;
      endcase
      if (nw > 0 && !v) nm[c] = val;
    end
    for (int c = 0; c < DEPTH; c++) model[c] = nm[c];
    if (arbhit) mptr = (mptr + 1) % N;
    e.c = ecol; e.i = evio; e.req = req;
    sb.push_back(e);
    @(posedge clk);
    @(negedge clk);
    clr();
  endtask

  // monitor: flags appear after the edge that registered them
  initial begin
    exp_t m;
    forever begin
      @(posedge clk); #1;
      if (sb.size() > 0) begin
        m = sb.pop_front();
        chk({m.req, " collision"}, conflict, m.c);
        chk({m.req, " violation"}, illegal, m.i);
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    for (int c = 0; c < DEPTH; c++) model[c] = '0;
    clr(); mode = 2'd1; policy = 3'd0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 read", rd_data, '0);
    chk("R1 collision", conflict, 1'b0);
    chk("R1 violation", illegal, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: same-cycle read of a written cell returns the old value
    wr(0, 1, 8'h11); wr(1, 2, 8'h22); wr(2, 3, 8'h33); wr(3, 4, 8'h44); rd(0, 1);
    go("R2", 2'd1, 3'd0);
    peek("R2", 1, 8'h11); peek("R2", 4, 8'h44);

    // R4: shared reads legal, double write illegal; R11 other cell commits
    rd(0, 2); rd(1, 2); rd(2, 2); wr(3, 7, 8'h55);
    go("R4", 2'd1, 3'd0);
    peek("R4", 7, 8'h55);
    wr(0, 2, 8'hAA); wr(1, 2, 8'hBB); wr(2, 9, 8'h99);
    go("R4", 2'd1, 3'd0);
    peek("R4", 2, 8'h22); peek("R11", 9, 8'h99);
    go("R11 quiet", 2'd1, 3'd0);

    // R3: exclusive discipline
    rd(0, 3); wr(1, 3, 8'hCC);
    go("R3", 2'd0, 3'd0);
    peek("R3", 3, 8'h33);
    rd(0, 4); rd(1, 4);
    go("R3", 2'd0, 3'd0);
    rd(0, 1); wr(1, 10, 8'hA5);
    go("R3", 2'd0, 3'd0);
    peek("R3", 10, 8'hA5);

    // R5: common policy
    wr(0, 5, 8'h5A); wr(2, 5, 8'h5A);
    go("R5", 2'd2, 3'd0);
    peek("R5", 5, 8'h5A);
    wr(1, 5, 8'h01); wr(3, 5, 8'h02);
    go("R5", 2'd3, 3'd0);
    peek("R5", 5, 8'h5A);

    // R7: rank policy, including reserved code 7
    wr(1, 11, 8'hB1); wr(2, 11, 8'hB2); wr(3, 11, 8'hB3);
    go("R7", 2'd2, 3'd2);
    peek("R7", 11, 8'hB1);
    wr(2, 12, 8'hC2); wr(3, 12, 8'hC3);
    go("R7", 2'd2, 3'd7);
    peek("R7", 12, 8'hC2);

    // R6: rotating choice
    for (int p = 0; p < N; p++) wr(p, 6, 8'h60 + 8'(p));
    go("R6", 2'd2, 3'd1);
    peek("R6", 6, 8'h60);
    for (int p = 0; p < N; p++) wr(p, 6, 8'h60 + 8'(p));
    go("R6", 2'd2, 3'd1);
    peek("R6", 6, 8'h61);
    wr(0, 6, 8'h70); wr(2, 6, 8'h72);
    go("R6", 2'd2, 3'd1);
    peek("R6", 6, 8'h72);
    wr(0, 6, 8'h80); wr(1, 6, 8'h81);
    go("R6", 2'd2, 3'd1);
    peek("R6", 6, 8'h80);
    wr(3, 13, 8'hD3);
    go("R6 lone", 2'd2, 3'd1);
    wr(0, 13, 8'h90); wr(1, 13, 8'h91);
    go("R6", 2'd2, 3'd1);
    peek("R6", 13, 8'h90);

    // R8: sum wraps
    wr(0, 14, 8'hC8); wr(1, 14, 8'h64);
    go("R8", 2'd2, 3'd3);
    peek("R8", 14, 8'h2C);
    wr(0, 15, 8'h01); wr(2, 15, 8'h02); wr(3, 15, 8'h03);
    go("R8", 2'd2, 3'd3);
    peek("R8", 15, 8'h06);

    // R9: bitwise AND
    wr(0, 8, 8'hF0); wr(1, 8, 8'h3C); wr(3, 8, 8'hFF);
    go("R9", 2'd2, 3'd4);
    peek("R9", 8, 8'h30);

    // R10: unsigned maximum
    wr(0, 0, 8'h17); wr(1, 0, 8'h9E); wr(2, 0, 8'h42); wr(3, 0, 8'h80);
    go("R10", 2'd2, 3'd5);
    peek("R10", 0, 8'h9E);

    go("R11 quiet", 2'd2, 3'd0);
    @(negedge clk);
    report();
  end

endmodule